// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the processor-facing half of an SPI master. A small register window holds the frame configuration, the control bits, a clock prescale value, a status word and an interrupt word. Writes to the data offset queue transmit frames into an 8-entry FIFO, and reads from that offset take received frames out of a second 8-entry FIFO. A serial frame engine, which is not part of this block, sits on the other side of the FIFOs. It takes transmit words through a valid/ready handshake and returns received words through a valid strobe.

Software sets the frame width, turns the port on and keeps the transmit FIFO topped up. It services interrupts when the receive FIFO reaches half depth or the transmit FIFO drains to half depth. A frame that arrives while the receive FIFO is full is lost. That loss raises a sticky overrun interrupt, which stays set until software writes the interrupt register. Turning the port off empties both FIFOs and stops the engine.

Top module: `spi_regfifo`

## Requirements
- R1: Byte offsets: control0 is 0x00 (16 bits, read/write), control1 is 0x04 (7 bits, read/write), data is 0x08, status is 0x0C, prescale is 0x10 (8 bits, read/write) and interrupt is 0x14. Other offsets read as 0. All registers reset to 0.
- R2: While the port is enabled, each write to the data offset appends the write data to the transmit FIFO. The engine receives the words in write order, one per cycle in which eng_tx_valid and eng_tx_ready are both high.
- R3: A data write while the transmit FIFO already holds 8 words is dropped. The FIFO keeps its contents and its count.
- R4: Status bits: bit0 is transmit FIFO empty, bit1 is transmit FIFO not full, bit2 is receive FIFO not empty, bit3 is receive FIFO full, bit4 is busy. After reset the status reads 0x03.
- R5: A read of the data offset returns the oldest received frame and removes it from the FIFO. A read while the FIFO is empty returns 0. A stored frame keeps only its low (control0[3:0]+1) bits, and the upper bits are 0.
- R6: Interrupt register bit0 is set when control1 bit0 is set and the receive FIFO holds 4 or more frames. Bit1 is set when control1 bit1 is set and the transmit FIFO holds 4 or fewer words.
- R7: A frame that arrives while the receive FIFO holds 8 frames, with no pop in the same cycle, is discarded. It sets a sticky overrun flag, which shows as interrupt register bit2 when control1 bit2 is set.
- R8: A write of any value to offset 0x14 clears the overrun flag.
- R9: While control1 bit4 (port enable) is 0, both FIFOs are held empty, data writes and arriving frames are ignored, and eng_en and eng_tx_valid are 0.
- R10: Busy (status bit4) is 1 while the transmit FIFO is not empty or eng_active is 1.
- R11: irq is the OR of interrupt register bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| eng_en | output | 1 | Port enable to the serial engine |
| eng_tx_valid | output | 1 | Transmit word available |
| eng_tx_ready | input | 1 | Engine takes the transmit word |
| eng_tx_data | output | 16 | Oldest transmit word |
| eng_rx_valid | input | 1 | Received frame strobe |
| eng_rx_data | input | 16 | Received frame |
| eng_active | input | 1 | Engine is shifting a frame |
| cfg_ctrl0 | output | 16 | Control0 contents (frame size, mode, divider) |
| cfg_ctrl1 | output | 7 | Control1 contents |
| cfg_prescale | output | 8 | Clock prescale value |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is an overrun. The receive FIFO must be filled to exactly eight frames with no pop, and a ninth frame must then arrive. After that, the flag has to stay set until the interrupt register is written. The bench drives the engine's receive strobe nine times in a row without reading, checks the interrupt word before and after the clearing write, and then drains the FIFO to show that the ninth frame never entered it. A full transmit FIFO is reached in a similar way, by holding the engine's ready low while nine words are written.

// File: rtl/spi_regfifo.sv
module spi_regfifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          eng_en,
  output logic          eng_tx_valid,
  input  logic          eng_tx_ready,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_valid,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_active,
  output logic [DW-1:0] cfg_ctrl0,
  output logic [6:0]    cfg_ctrl1,
  output logic [7:0]    cfg_prescale,
  output logic          irq
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;
  localparam int HALF = DEPTH / 2;

  logic [DW-1:0] ctrl0_q;
  logic [6:0]    ctrl1_q;
  logic [7:0]    presc_q;
  logic          ovr_q;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire en      = ctrl1_q[4];
  wire wr_acc  = bus_sel && bus_wr;
  wire rd_acc  = bus_sel && !bus_wr;
  wire [2:0] sel_idx = bus_addr[4:2];
  wire wr_data = wr_acc && sel_idx == 3'd2;
  wire wr_icr  = wr_acc && sel_idx == 3'd5;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;

  wire tx_push = en && wr_data && !tx_full;
  wire tx_pop  = eng_tx_valid && eng_tx_ready;
  wire rx_pop  = en && rd_acc && sel_idx == 3'd2 && !rx_empty;
  wire rx_push = en && eng_rx_valid && (!rx_full || rx_pop);
  wire ovr_set = en && eng_rx_valid && rx_full && !rx_pop;

  wire [16:0]   fmask   = (17'd2 << ctrl0_q[3:0]) - 17'd1;
  wire [DW-1:0] rx_word = eng_rx_data & fmask[DW-1:0];

  wire       busy    = !tx_empty || eng_active;
  wire [4:0] status  = {busy, rx_full, !rx_empty, !tx_full, tx_empty};
  wire [2:0] int_vec = {ovr_q & ctrl1_q[2],
                        (tx_cnt <= CW'(HALF)) & ctrl1_q[1],
                        (rx_cnt >= CW'(HALF)) & ctrl1_q[0]};

  assign eng_en       = en;
  assign eng_tx_valid = en && !tx_empty;
  assign eng_tx_data  = tx_mem[tx_rp];
  assign cfg_ctrl0    = ctrl0_q;
  assign cfg_ctrl1    = ctrl1_q;
  assign cfg_prescale = presc_q;
  assign irq          = |int_vec;

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (sel_idx)
        3'd0: bus_rdata = ctrl0_q;
        3'd1: bus_rdata = DW'(ctrl1_q);
        3'd2: bus_rdata = rx_empty ? '0 : rx_mem[rx_rp];
        3'd3: bus_rdata = DW'(status);
        3'd4: bus_rdata = DW'(presc_q);
        3'd5: bus_rdata = DW'(int_vec);
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= '0; ctrl1_q <= '0; presc_q <= '0; ovr_q <= 1'b0;
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (wr_acc && sel_idx == 3'd0) ctrl0_q <= bus_wdata;
      if (wr_acc && sel_idx == 3'd1) ctrl1_q <= bus_wdata[6:0];
      if (wr_acc && sel_idx == 3'd4) presc_q <= bus_wdata[7:0];
      if (ovr_set)     ovr_q <= 1'b1;
      else if (wr_icr) ovr_q <= 1'b0;
      if (!en) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (tx_pop)  tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)  rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      end
    end
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && wr_data && !tx_pop) |=> (tx_full && $stable(tx_wp))); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !wr_icr) |=> ovr_q); // R7
  AST_ICR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_icr && !ovr_set) |=> !ovr_q); // R8
  AST_FLUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_empty && rx_empty)); // R9
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |-> !eng_tx_valid); // R9
endmodule

// File: tb/spi_regfifo_tb_top.sv
module spi_regfifo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, eng_tx_ready = 0, eng_rx_valid = 0, eng_active = 0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, eng_rx_data = '0;
  logic [15:0] bus_rdata, eng_tx_data, cfg_ctrl0;
  logic [6:0] cfg_ctrl1;
  logic [7:0] cfg_prescale;
  logic eng_en, eng_tx_valid, irq;
  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  logic [15:0] rd;

  always #5 clk = ~clk;

  spi_regfifo dut_i (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .eng_en, .eng_tx_valid, .eng_tx_ready, .eng_tx_data, .eng_rx_valid, .eng_rx_data,
    .eng_active, .cfg_ctrl0, .cfg_ctrl1, .cfg_prescale, .irq);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic send(input logic [15:0] w, input bit accepted);
    if (accepted) exp_q.push_back(w);
    wr(5'h08, w);
  endtask

  task automatic rx_in(input logic [15:0] d);
    @(negedge clk); eng_rx_valid = 1; eng_rx_data = d;
    @(negedge clk); eng_rx_valid = 0;
  endtask

  always @(posedge clk) begin
    if (rst_n && eng_tx_valid && eng_tx_ready) begin
      if (exp_q.size() == 0) chk("R2 unexpected tx word", {16'h0, eng_tx_data}, 32'hdead);
      else chk("R2 tx order", {16'h0, eng_tx_data}, {16'h0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rdreg(5'h0C, rd); chk("R4 reset status", rd, 16'h03);
    rdreg(5'h00, rd); chk("R1 reset ctrl0", rd, 0);
    rdreg(5'h14, rd); chk("R11 reset int", rd, 0);
    chk("R11 reset irq", irq, 0);
    wr(5'h00, 16'h12F7); rdreg(5'h00, rd); chk("R1 ctrl0", rd, 16'h12F7);
    wr(5'h04, 16'hFFFF); rdreg(5'h04, rd); chk("R1 ctrl1", rd, 16'h7F);
    wr(5'h10, 16'h01FE); rdreg(5'h10, rd); chk("R1 prescale", rd, 16'hFE);
    rdreg(5'h18, rd); chk("R1 unused offset", rd, 0);
    wr(5'h04, 16'h10);
    wr(5'h14, 0);
    // R2 / R3: fill with engine stalled, ninth dropped
    for (int i = 0; i < 9; i++) send(16'hA0 + 16'(i), i < 8);
    rdreg(5'h0C, rd); chk("R3 R4 R10 full status", rd, 16'h10);
    @(negedge clk); eng_tx_ready = 1;
    repeat (12) @(negedge clk);
    chk("R2 all words delivered", exp_q.size(), 0);
    rdreg(5'h0C, rd); chk("R4 drained status", rd, 16'h03);
    eng_active = 1; rdreg(5'h0C, rd); chk("R10 busy from engine", rd, 16'h13);
    eng_active = 0;
    send(16'h5A5A, 1); send(16'h0F0F, 1);
    repeat (4) @(negedge clk);
    chk("R2 short burst", exp_q.size(), 0);
    // R5 receive path and masking
    rx_in(16'h01A5); rdreg(5'h08, rd); chk("R5 8-bit frame", rd, 16'h00A5);
    rdreg(5'h08, rd); chk("R5 empty read", rd, 0);
    wr(5'h00, 16'h000F); rx_in(16'hBEEF); rdreg(5'h08, rd); chk("R5 16-bit frame", rd, 16'hBEEF);
    wr(5'h00, 16'h0003); rx_in(16'hFFFF); rdreg(5'h08, rd); chk("R5 4-bit frame", rd, 16'h000F);
    wr(5'h00, 16'h000F);
    // R6 R7 R8 R11 interrupts
    wr(5'h04, 16'h17);
    rdreg(5'h14, rd); chk("R6 tx half int", rd, 16'h2); chk("R11 irq", irq, 1);
    for (int i = 0; i < 3; i++) rx_in(16'h100 + 16'(i));
    rdreg(5'h14, rd); chk("R6 rx below half", rd, 16'h2);
    rx_in(16'h103);
    rdreg(5'h14, rd); chk("R6 rx half int", rd, 16'h3);
    for (int i = 4; i < 8; i++) rx_in(16'h100 + 16'(i));
    rdreg(5'h0C, rd); chk("R4 rx full status", rd, 16'h0F);
    rdreg(5'h14, rd); chk("R7 no overrun yet", rd, 16'h3);
    rx_in(16'h0999);
    rdreg(5'h14, rd); chk("R7 overrun flag", rd, 16'h7);
    repeat (3) @(negedge clk);
    rdreg(5'h14, rd); chk("R7 overrun sticky", rd, 16'h7);
    wr(5'h14, 16'h1234);
    rdreg(5'h14, rd); chk("R8 overrun cleared", rd, 16'h3);
    for (int i = 0; i < 8; i++) begin
      rdreg(5'h08, rd); chk("R7 kept frames", rd, 16'h100 + 16'(i));
    end
    rdreg(5'h08, rd); chk("R7 ninth discarded", rd, 0);
    rdreg(5'h14, rd); chk("R6 rx int gone", rd, 16'h2);
    wr(5'h04, 16'h10);
    rdreg(5'h14, rd); chk("R6 gated off", rd, 0); chk("R11 irq off", irq, 0);
    // R9 disable flush
    @(negedge clk); eng_tx_ready = 0;
    send(16'h1111, 1); send(16'h2222, 1); send(16'h3333, 1);
    rx_in(16'h0044); rx_in(16'h0055);
    rdreg(5'h0C, rd); chk("R10 busy tx pending", rd, 16'h16);
    wr(5'h04, 16'h00); exp_q.delete();
    rdreg(5'h0C, rd); chk("R9 flushed status", rd, 16'h03);
    chk("R9 engine idle", {eng_en, eng_tx_valid}, 0);
    wr(5'h08, 16'h7777); rx_in(16'h0066);
    rdreg(5'h0C, rd); chk("R9 ignored while off", rd, 16'h03);
    wr(5'h04, 16'h10);
    rdreg(5'h08, rd); chk("R9 rx empty after flush", rd, 0);
    @(negedge clk); eng_tx_ready = 1;
    send(16'hC0DE, 1); send(16'hFACE, 1);
    repeat (4) @(negedge clk);
    chk("R9 R2 resume after flush", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule